// File: doc/BRIEF.md
# Multi-Channel Over-Temperature Output Comparator

This block watches three temperature channels (remote channel 1, the local channel and remote channel 2) and drives one shared active-low over-temperature line. Each channel holds a trip state. The state is re-evaluated only when that channel's end-of-conversion strobe arrives, so a trip lasts at least one full monitoring cycle. Readings carry a two-bit quarter-degree fraction. Limits are whole degrees.

A mode bit selects the number coding of both readings and limits: plain two's complement, or offset-64 coding in which the stored integer is 64 above the true value. The lowest limit codes of each coding act as a per-channel disable. A configuration bit turns hysteresis off, and each channel has its own enable bit. The line is low while any active channel is tripped. The line comes from a register that updates on the same edge as the trip states.

Top module: `overtemp_cmp`

## Requirements
- R1: While and after reset, `therm_n` is 1 and every channel's trip state is clear.
- R2: On the clock edge that samples a channel's strobe, an active channel whose reading is at least `TRIP_MARGIN_Q` quarter-degrees above its limit trips (default 1, i.e. 0.25 °C), and `therm_n` reflects it on that same edge.
- R3: With hysteresis on, a tripped channel releases only at a strobe where its reading is equal to or below its limit.
- R4: Between a channel's strobes, its trip state does not change when its reading changes; a strobe for one channel does not re-evaluate the others.
- R5: With hysteresis on, a strobe whose reading is above the limit but below the trip threshold keeps the previous trip state.
- R6: With `hyst_off` = 1, at each strobe the trip state becomes exactly the trip comparison of R2.
- R7: `ch_enable` bit 0 is remote 1, bit 1 is local and bit 2 is remote 2. A channel whose bit is 0 is cleared on the next edge, even when its strobe is present in the same cycle, and it never pulls the output low.
- R8: With `offset_mode` = 1, a limit code of 1 or less (−63 °C or lower) disables the channel as in R7. Code 2 (−62 °C) is a working limit.
- R9: With `offset_mode` = 0, limit code 0x80 (−128 °C) disables the channel as in R7. Code 0x81 (−127 °C) is a working limit.
- R10: With `offset_mode` = 1, the integer field of a reading and the limit code both stand for their value minus 64. With `offset_mode` = 0 they are two's complement. A reading holds the integer in bits [9:2] and the quarter-degree fraction in bits [1:0].
- R11: `therm_n` is low exactly when at least one channel is tripped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| offset_mode | input | 1 | 1 = offset-64 coding, 0 = two's complement |
| hyst_off | input | 1 | 1 = trip state follows the comparison at each strobe |
| ch_enable | input | 3 | Per-channel enable (bit 0 remote 1, bit 1 local, bit 2 remote 2) |
| conv_done | input | 3 | Per-channel end-of-conversion strobe, one cycle |
| temp_raw | input | 30 | Readings, channel i in bits [10i+9:10i] |
| limit_raw | input | 24 | Limit codes, channel i in bits [8i+7:8i] |
| therm_n | output | 1 | Active-low over-temperature output |

## Verification
A trip evaluation can fall in the same cycle as the clearing of that channel. This happens when the channel's strobe carries a hot reading while its enable bit is low, or while its limit holds the disable code. The bench provokes both cases: it drives a strobe with a hot reading in the same cycle that the local channel's enable is zero, and in the same cycle that an offset-mode limit of code 1 is present. In both cases the clear must win, and the bench judges this by `therm_n` staying high at the sample after that edge. A second coincidence is one channel releasing while another stays tripped. The bench checks that the output stays low until the last tripped channel releases.

// File: rtl/otc_pkg.sv
package otc_pkg;
  localparam int OTC_INT_W  = 8;
  localparam int OTC_FRAC_W = 2;
  localparam int OTC_NUM_CH = 3;

  typedef enum logic {
    CODE_TWOS   = 1'b0,
    CODE_OFFSET = 1'b1
  } code_e;
endpackage

// File: rtl/otc_decode.sv
module otc_decode #(
  parameter int INT_W  = otc_pkg::OTC_INT_W,
  parameter int FRAC_W = otc_pkg::OTC_FRAC_W,
  localparam int TW    = INT_W + FRAC_W,
  localparam int Q_W   = INT_W + 1 + FRAC_W
) (
  input  logic                  offset_mode,
  input  logic [TW-1:0]         temp_raw,
  input  logic [INT_W-1:0]      limit_raw,
  output logic signed [Q_W-1:0] temp_q,
  output logic signed [Q_W-1:0] limit_q,
  output logic                  dis_code
);
  localparam logic signed [INT_W:0] OFF_S   = (INT_W+1)'(1 << (INT_W-2));
  localparam logic signed [INT_W:0] OFF_DIS = (INT_W+1)'(1 - (1 << (INT_W-2)));
  localparam logic [INT_W-1:0]      TWOS_MIN = {1'b1, {(INT_W-1){1'b0}}};

  logic signed [INT_W:0] t_int;
  logic signed [INT_W:0] l_int;

  always_comb begin
    if (otc_pkg::code_e'(offset_mode) == otc_pkg::CODE_OFFSET) begin
      t_int    = $signed({1'b0, temp_raw[TW-1:FRAC_W]}) - OFF_S;
      l_int    = $signed({1'b0, limit_raw}) - OFF_S;
      dis_code = (l_int <= OFF_DIS);
    end else begin
      t_int    = $signed({temp_raw[TW-1], temp_raw[TW-1:FRAC_W]});
      l_int    = $signed({limit_raw[INT_W-1], limit_raw});
      dis_code = (limit_raw == TWOS_MIN);
    end
    temp_q  = {t_int, temp_raw[FRAC_W-1:0]};
    limit_q = {l_int, {FRAC_W{1'b0}}};
  end
endmodule

// File: rtl/otc_channel.sv
module otc_channel #(
  parameter int Q_W           = 11,
  parameter int TRIP_MARGIN_Q = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  strobe,
  input  logic                  active,
  input  logic                  hyst_off,
  input  logic signed [Q_W-1:0] temp_q,
  input  logic signed [Q_W-1:0] limit_q,
  output logic                  trip_d,
  output logic                  trip_q
);
  logic signed [Q_W:0] thr;
  logic                hot;
  logic                cool;

  always_comb begin
    thr  = $signed({limit_q[Q_W-1], limit_q}) + $signed((Q_W+1)'(TRIP_MARGIN_Q));
    hot  = $signed({temp_q[Q_W-1], temp_q}) >= thr;
    cool = temp_q <= limit_q;
  end

  always_comb begin
    trip_d = trip_q;
    if (!active)
      trip_d = 1'b0;
    else if (strobe) begin
      if (hyst_off)  trip_d = hot;
      else if (hot)  trip_d = 1'b1;
      else if (cool) trip_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) trip_q <= 1'b0;
    else     trip_q <= trip_d;
  end

  // R2: hot reading at a strobe on an active channel trips it
  p_trip_on_hot_r2: assert property (@(posedge clk) disable iff (rst)
    (strobe && active && hot) |=> trip_q);
  // R3: a strobe at or below the limit releases it
  p_release_cool_r3: assert property (@(posedge clk) disable iff (rst)
    (strobe && active && cool) |=> !trip_q);
  // R4: no strobe, no change while active
  p_hold_no_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    (!strobe && active) |=> (trip_q == $past(trip_q)));
  // R7: an inactive channel is clear on the next edge
  p_inactive_clear_r7: assert property (@(posedge clk) disable iff (rst)
    !active |=> !trip_q);
endmodule

// File: rtl/overtemp_cmp.sv
module overtemp_cmp #(
  parameter int INT_W         = otc_pkg::OTC_INT_W,
  parameter int FRAC_W        = otc_pkg::OTC_FRAC_W,
  parameter int NUM_CH        = otc_pkg::OTC_NUM_CH,
  parameter int TRIP_MARGIN_Q = 1,
  localparam int TW           = INT_W + FRAC_W,
  localparam int Q_W          = INT_W + 1 + FRAC_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    offset_mode,
  input  logic                    hyst_off,
  input  logic [NUM_CH-1:0]       ch_enable,
  input  logic [NUM_CH-1:0]       conv_done,
  input  logic [NUM_CH*TW-1:0]    temp_raw,
  input  logic [NUM_CH*INT_W-1:0] limit_raw,
  output logic                    therm_n
);
  logic [NUM_CH-1:0] trip_d;
  logic [NUM_CH-1:0] trip_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic signed [Q_W-1:0] temp_q;
    logic signed [Q_W-1:0] limit_q;
    logic                  dis_code;

    otc_decode #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_dec (
      .offset_mode (offset_mode),
      .temp_raw    (temp_raw[g*TW +: TW]),
      .limit_raw   (limit_raw[g*INT_W +: INT_W]),
      .temp_q      (temp_q),
      .limit_q     (limit_q),
      .dis_code    (dis_code)
    );

    otc_channel #(.Q_W(Q_W), .TRIP_MARGIN_Q(TRIP_MARGIN_Q)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .strobe   (conv_done[g]),
      .active   (ch_enable[g] && !dis_code),
      .hyst_off (hyst_off),
      .temp_q   (temp_q),
      .limit_q  (limit_q),
      .trip_d   (trip_d[g]),
      .trip_q   (trip_q[g])
    );

    // R8 R9: a disable-code limit keeps the channel clear
    p_dis_code_clear_r8: assert property (@(posedge clk) disable iff (rst)
      dis_code |=> !trip_q[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) therm_n <= 1'b1;
    else     therm_n <= ~|trip_d;
  end

  // R11: output low exactly when some channel is tripped
  p_out_or_r11: assert property (@(posedge clk) disable iff (rst)
    therm_n == !(|trip_q));
  // R1: reset leaves the output released
  p_reset_high_r1: assert property (@(posedge clk)
    rst |=> therm_n);
endmodule

// File: tb/overtemp_cmp_tb.sv
`timescale 1ns/1ps
module overtemp_cmp_tb;
  localparam int M = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        offset_mode = 1'b0;
  logic        hyst_off = 1'b0;
  logic [2:0]  ch_enable = 3'b111;
  logic [2:0]  conv_done = 3'b000;
  logic [9:0]  t_raw [3];
  logic [7:0]  l_raw [3];
  logic        therm_n;

  int n_chk = 0;
  int n_fail = 0;
  bit   exp_q [$];
  string tag_q [$];
  bit   m_st [3];

  always #4 clk = ~clk;

  overtemp_cmp #(.TRIP_MARGIN_Q(M)) u_dut (
    .clk(clk), .rst(rst), .offset_mode(offset_mode), .hyst_off(hyst_off),
    .ch_enable(ch_enable), .conv_done(conv_done),
    .temp_raw({t_raw[2], t_raw[1], t_raw[0]}),
    .limit_raw({l_raw[2], l_raw[1], l_raw[0]}),
    .therm_n(therm_n)
  );

  function automatic logic [9:0] enc_t(int q, bit mode);
    return mode ? 10'(q + 256) : 10'(q);
  endfunction
  function automatic logic [7:0] enc_l(int d, bit mode);
    return mode ? 8'(d + 64) : 8'(d);
  endfunction
  function automatic int dec_t(logic [9:0] r, bit mode);
    int i;
    i = mode ? int'(r[9:2]) - 64 : int'($signed(r[9:2]));
    return i * 4 + int'(r[1:0]);
  endfunction
  function automatic int dec_l(logic [7:0] r, bit mode);
    return mode ? int'(r) - 64 : int'($signed(r));
  endfunction

  task automatic check(input bit act, input bit exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: therm_n actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] strb, input string tag);
    bit any;
    @(negedge clk);
    conv_done = strb;
    @(posedge clk);
    any = 1'b0;
    for (int c = 0; c < 3; c++) begin
      int t, lq;
      bit dis, act, hot, cool;
      t   = dec_t(t_raw[c], offset_mode);
      lq  = dec_l(l_raw[c], offset_mode) * 4;
      dis = offset_mode ? (l_raw[c] <= 8'd1) : (l_raw[c] == 8'h80);
      act = ch_enable[c] && !dis;
      hot  = t >= lq + M;
      cool = t <= lq;
      if (!act) m_st[c] = 1'b0;
      else if (strb[c]) begin
        if (hyst_off)  m_st[c] = hot;
        else if (hot)  m_st[c] = 1'b1;
        else if (cool) m_st[c] = 1'b0;
      end
      any |= m_st[c];
    end
    exp_q.push_back(!any);
    tag_q.push_back(tag);
    #1;
    conv_done = 3'b000;
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      bit e;
      string s;
      e = exp_q.pop_front();
      s = tag_q.pop_front();
      check(therm_n, e, s);
    end
  end

  initial begin
    #(200000 * 8);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int c = 0; c < 3; c++) begin
      t_raw[c] = 10'd0;
      m_st[c] = 1'b0;
    end
    l_raw[0] = enc_l(80, 0);
    l_raw[1] = enc_l(50, 0);
    l_raw[2] = enc_l(90, 0);
    t_raw[0] = enc_t(400, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(therm_n, 1'b1, "R1 reset");
    rst = 1'b0;
    step(3'b000, "R1 after reset");

    t_raw[0] = enc_t(320, 0); step(3'b001, "R2 at limit no trip");
    t_raw[0] = enc_t(321, 0); step(3'b001, "R5 band keeps clear");
    t_raw[0] = enc_t(322, 0); step(3'b001, "R2 trip at threshold");
    t_raw[0] = enc_t(80, 0);  step(3'b000, "R4 no strobe holds");
    step(3'b110, "R4 other strobes ignore ch0");
    t_raw[0] = enc_t(321, 0); step(3'b001, "R5 band keeps trip");
    t_raw[0] = enc_t(320, 0); step(3'b001, "R3 release at limit");

    t_raw[1] = enc_t(240, 0); step(3'b010, "R11 local trips");
    t_raw[2] = enc_t(380, 0); step(3'b100, "R11 remote2 trips");
    t_raw[1] = enc_t(160, 0); step(3'b010, "R11 one still tripped");
    t_raw[2] = enc_t(340, 0); step(3'b100, "R11 all released");

    ch_enable = 3'b101;
    t_raw[1] = enc_t(240, 0); step(3'b010, "R7 disabled local ignored");
    ch_enable = 3'b111;
    t_raw[1] = enc_t(160, 0);
    t_raw[2] = enc_t(380, 0); step(3'b100, "R7 remote2 trips");
    ch_enable = 3'b011;       step(3'b000, "R7 enable drop clears");
    ch_enable = 3'b111;
    t_raw[2] = enc_t(340, 0); step(3'b100, "R7 remote2 idle");

    hyst_off = 1'b1;
    t_raw[0] = enc_t(324, 0); step(3'b001, "R6 trip");
    t_raw[0] = enc_t(321, 0); step(3'b001, "R6 band clears");
    t_raw[0] = enc_t(322, 0); step(3'b001, "R6 retrip");
    t_raw[0] = enc_t(320, 0); step(3'b001, "R6 release");
    hyst_off = 1'b0;

    l_raw[0] = 8'h80;
    t_raw[0] = enc_t(400, 0);   step(3'b001, "R9 code 0x80 disables");
    l_raw[0] = 8'h81;
    t_raw[0] = enc_t(-400, 0);  step(3'b001, "R9 code 0x81 works");
    t_raw[0] = enc_t(-508, 0);  step(3'b001, "R9 release");

    offset_mode = 1'b1;
    t_raw[1] = enc_t(0, 1);
    t_raw[2] = enc_t(0, 1);
    l_raw[0] = 8'd1;
    t_raw[0] = enc_t(-244, 1);  step(3'b001, "R8 code 1 disables");
    l_raw[0] = 8'd2;            step(3'b001, "R8 code 2 trips");
    t_raw[0] = enc_t(-248, 1);  step(3'b001, "R8 release");
    l_raw[0] = enc_l(80, 1);
    t_raw[0] = enc_t(322, 1);   step(3'b001, "R10 offset trip");
    t_raw[0] = enc_t(321, 1);   step(3'b001, "R10 offset band holds");
    t_raw[0] = enc_t(320, 1);   step(3'b001, "R10 offset release");

    repeat (3) @(posedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule